// File: doc/BRIEF.md
# Output Line Stripe Selector

This block decides how many serial data output lines a playback stream should be spread across. It takes the stream's channel count, sample width and sample rate, a per-bus minimum per-line bandwidth threshold, and the largest line count the bus offers. On a start pulse it captures these values, works out the stream's bandwidth figure, and then tries candidate line counts from the largest downward, halving after each miss. It evaluates one candidate per clock cycle.

The first candidate whose per-line share of the bandwidth figure reaches the threshold is chosen, and its line count is turned into a small stripe code. If every candidate misses, the code falls back to the single-line value. A one-cycle done pulse marks the result, and the code stays on its output until the next evaluation completes. Decoding the capability word out of a register and the serializer itself sit elsewhere.

Top module: `lane_stripe_sel`

## Requirements
- R1: The channel count, sample width, rate, threshold and maximum line count are captured on the clock edge where start_i is accepted. Later changes to these inputs do not alter the result of that evaluation.
- R2: The first candidate is the captured maximum line count. After each candidate that misses, the next candidate is the previous one shifted right by one bit. A candidate of zero ends the search.
- R3: The rate multiplier is floor(rate / 48000) when the rate is above 48000 and 1 otherwise. The bandwidth figure is channels × sample width × multiplier.
- R4: The per-line load of a candidate is the bandwidth figure shifted right by log2 of the candidate, which is integer division with truncation. Line counts are 0 or powers of two.
- R5: The search selects the first candidate whose per-line load is greater than or equal to the threshold. Equality counts as a pass.
- R6: The stripe code is the selected line count shifted right by one: 0 for one line, 1 for two lines, 2 for four lines.
- R7: If no candidate passes, the code is 0.
- R8: A maximum line count of 0 gives done one cycle after the start edge, with code 0.
- R9: done_o is high for exactly one cycle. It appears N cycles after the start edge, where N is the number of nonzero candidates tried, with a minimum of 1.
- R10: A start_i pulse that arrives while a search is in progress is ignored. It neither changes that result nor produces an extra done pulse.
- R11: After reset, done_o is 0 and code_o is 0.
- R12: code_o changes only in the cycle where done_o is high, and it keeps its value between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an evaluation (accepted when idle) |
| chan_i | input | CH_W | Channel count |
| bits_i | input | BITS_W | Bits per sample |
| rate_i | input | RATE_W | Sample rate in Hz |
| thresh_i | input | THR_W | Minimum per-line load |
| max_lines_i | input | LINES_W | Maximum line count (0 or a power of two) |
| code_o | output | LINES_W-1 | Stripe code |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The bench builds the block with its default parameters: a 4-bit channel count, a 6-bit sample width, an 18-bit rate and a 3-bit line count. With these values the rate multiplier can reach 5, so the boundaries between multipliers are all within reach, including 48000 against 48001 and 95999 against 96000. Line counts of 0, 1, 2 and 4 cover every search length from one to three candidates. Directed cases cover an exact threshold match, a truncated quotient, and a search where every candidate misses. Random cases check both the code and the cycle of done against a model that uses true division in place of shifts.

// File: rtl/stripe_pkg.sv
package stripe_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SEARCH = 1'b1
  } sel_state_e;

  localparam int unsigned BASE_RATE = 48000;

  // index of the highest set bit; equals log2 for a power of two
  function automatic int unsigned hi_bit(input int unsigned v);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/stripe_load_calc.sv
module stripe_load_calc #(
  parameter int CH_W   = 4,
  parameter int BITS_W = 6,
  parameter int RATE_W = 18,
  parameter int MULT_W = 3,
  parameter int LOAD_W = 13
) (
  input  logic [CH_W-1:0]   chan_i,
  input  logic [BITS_W-1:0] bits_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [LOAD_W-1:0] load_o,
  output logic [MULT_W-1:0] mult_o
);
  import stripe_pkg::*;

  localparam int unsigned MULT_MAX = ((2 ** RATE_W) - 1) / BASE_RATE;

  // floor(rate / BASE_RATE) above the base rate, else 1
  function automatic logic [MULT_W-1:0] rate_mult(input logic [RATE_W-1:0] r);
    logic [MULT_W-1:0] q;
    q = MULT_W'(1);
    for (int unsigned k = 2; k <= MULT_MAX; k++) begin
      if (32'(r) >= k * BASE_RATE) q = MULT_W'(k);
    end
    return q;
  endfunction

  assign mult_o = rate_mult(rate_i);
  assign load_o = LOAD_W'(chan_i) * LOAD_W'(bits_i) * LOAD_W'(mult_o);

endmodule

// File: rtl/stripe_cand_eval.sv
module stripe_cand_eval #(
  parameter int LOAD_W  = 13,
  parameter int THR_W   = 16,
  parameter int LINES_W = 3
) (
  input  logic [LOAD_W-1:0]  load_i,
  input  logic [THR_W-1:0]   thr_i,
  input  logic [LINES_W-1:0] cand_i,
  output logic [LOAD_W-1:0]  per_line_o,
  output logic               hit_o
);
  import stripe_pkg::*;

  localparam int CMP_W = (LOAD_W > THR_W) ? LOAD_W : THR_W;

  function automatic logic [LOAD_W-1:0] share(input logic [LOAD_W-1:0] l,
                                               input logic [LINES_W-1:0] c);
    return l >> hi_bit(32'(c));
  endfunction

  assign per_line_o = share(load_i, cand_i);
  assign hit_o      = (cand_i != '0) && (CMP_W'(per_line_o) >= CMP_W'(thr_i));

endmodule

// File: rtl/stripe_search_ctrl.sv
module stripe_search_ctrl #(
  parameter int LOAD_W  = 13,
  parameter int THR_W   = 16,
  parameter int LINES_W = 3,
  parameter int CODE_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [LOAD_W-1:0]  load_i,
  input  logic [THR_W-1:0]   thr_i,
  input  logic [LINES_W-1:0] max_lines_i,
  input  logic               hit_i,
  output logic [LOAD_W-1:0]  load_q,
  output logic [THR_W-1:0]   thr_q,
  output logic [LINES_W-1:0] cand_q,
  output logic               searching_o,
  output logic [CODE_W-1:0]  code_o,
  output logic               done_o
);
  import stripe_pkg::*;

  sel_state_e        state_q;
  logic [LINES_W-1:0] next_cand;
  logic               last_try;

  assign next_cand   = cand_q >> 1;
  assign last_try    = hit_i || (next_cand == '0);
  assign searching_o = (state_q == ST_SEARCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      load_q  <= '0;
      thr_q   <= '0;
      cand_q  <= '0;
      code_o  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            load_q  <= load_i;
            thr_q   <= thr_i;
            cand_q  <= max_lines_i;
            state_q <= ST_SEARCH;
          end
        end
        ST_SEARCH: begin
          if (last_try) begin
            done_o  <= 1'b1;
            code_o  <= hit_i ? CODE_W'(cand_q >> 1) : '0;
            state_q <= ST_IDLE;
          end else begin
            cand_q <= next_cand;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lane_stripe_sel.sv
module lane_stripe_sel #(
  parameter int CH_W    = 4,
  parameter int BITS_W  = 6,
  parameter int RATE_W  = 18,
  parameter int THR_W   = 16,
  parameter int LINES_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [CH_W-1:0]    chan_i,
  input  logic [BITS_W-1:0]  bits_i,
  input  logic [RATE_W-1:0]  rate_i,
  input  logic [THR_W-1:0]   thresh_i,
  input  logic [LINES_W-1:0] max_lines_i,
  output logic [LINES_W-2:0] code_o,
  output logic               done_o
);
  import stripe_pkg::*;

  localparam int MULT_MAX = ((2 ** RATE_W) - 1) / BASE_RATE;
  localparam int MULT_W   = $clog2(MULT_MAX + 2);
  localparam int LOAD_W   = CH_W + BITS_W + MULT_W;
  localparam int CODE_W   = LINES_W - 1;

  // named internal events, used by the bound checker
  logic [LOAD_W-1:0]  base_load_w;
  logic [MULT_W-1:0]  mult_w;
  logic [LOAD_W-1:0]  load_q_w;
  logic [THR_W-1:0]   thr_q_w;
  logic [LINES_W-1:0] cand_w;
  logic [LOAD_W-1:0]  per_line_w;
  logic               hit_w;
  logic               searching_w;

  stripe_load_calc #(
    .CH_W(CH_W), .BITS_W(BITS_W), .RATE_W(RATE_W),
    .MULT_W(MULT_W), .LOAD_W(LOAD_W)
  ) u_calc (
    .chan_i(chan_i), .bits_i(bits_i), .rate_i(rate_i),
    .load_o(base_load_w), .mult_o(mult_w)
  );

  stripe_cand_eval #(
    .LOAD_W(LOAD_W), .THR_W(THR_W), .LINES_W(LINES_W)
  ) u_eval (
    .load_i(load_q_w), .thr_i(thr_q_w), .cand_i(cand_w),
    .per_line_o(per_line_w), .hit_o(hit_w)
  );

  stripe_search_ctrl #(
    .LOAD_W(LOAD_W), .THR_W(THR_W), .LINES_W(LINES_W), .CODE_W(CODE_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .load_i(base_load_w), .thr_i(thresh_i), .max_lines_i(max_lines_i),
    .hit_i(hit_w), .load_q(load_q_w), .thr_q(thr_q_w), .cand_q(cand_w),
    .searching_o(searching_w), .code_o(code_o), .done_o(done_o)
  );

endmodule

// File: rtl/stripe_sel_chk.sv
module stripe_sel_chk #(
  parameter int LINES_W = 3,
  parameter int CODE_W  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic [LINES_W-1:0] max_lines_i,
  input logic               searching_w,
  input logic [LINES_W-1:0] cand_w,
  input logic               hit_w,
  input logic               done_o,
  input logic [CODE_W-1:0]  code_o
);

  assert_first_cand_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !searching_w) |=> (searching_w && cand_w == $past(max_lines_i)));

  assert_halve_on_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (searching_w && !hit_w && cand_w > 1) |=> (searching_w && cand_w == ($past(cand_w) >> 1)));

  assert_hit_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (searching_w && hit_w) |=> (done_o && code_o == CODE_W'($past(cand_w) >> 1)));

  assert_all_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (searching_w && !hit_w && cand_w <= 1) |=> (done_o && code_o == '0));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_code_form_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $onehot0(code_o));

  assert_code_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(code_o));

  assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (searching_w && start_i && !hit_w && cand_w > 1) |=> (cand_w == ($past(cand_w) >> 1)));

endmodule

bind lane_stripe_sel stripe_sel_chk #(
  .LINES_W(LINES_W), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .max_lines_i(max_lines_i),
  .searching_w(searching_w), .cand_w(cand_w), .hit_w(hit_w),
  .done_o(done_o), .code_o(code_o)
);

// File: tb/lane_stripe_sel_tb.sv
module lane_stripe_sel_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  chan_i = '0;
  logic [5:0]  bits_i = '0;
  logic [17:0] rate_i = '0;
  logic [15:0] thresh_i = '0;
  logic [2:0]  max_lines_i = '0;
  logic [1:0]  code_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  lane_stripe_sel u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
    .bits_i(bits_i), .rate_i(rate_i), .thresh_i(thresh_i),
    .max_lines_i(max_lines_i), .code_o(code_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // model using true division rather than shifts
  task automatic model(input int ch, input int bw, input int rate, input int thr,
                       input int maxl, output int code, output int lat);
    int mult;
    int base;
    int n;
    int tried;
    mult  = (rate > 48000) ? rate / 48000 : 1;
    base  = ch * bw * mult;
    n     = maxl;
    tried = 0;
    code  = 0;
    while (n > 0) begin
      tried++;
      if (base / n >= thr) begin
        code = n / 2;
        break;
      end
      n = n / 2;
    end
    lat = (tried == 0) ? 1 : tried;
  endtask

  task automatic run_case(input int ch, input int bw, input int rate, input int thr,
                          input int maxl, input string tag, input bit poke);
    int ecode;
    int elat;
    int lat;
    bit got;
    model(ch, bw, rate, thr, maxl, ecode, elat);
    @(negedge clk);
    chan_i = 4'(ch); bits_i = 6'(bw); rate_i = 18'(rate);
    thresh_i = 16'(thr); max_lines_i = 3'(maxl);
    start_i = 1'b1;
    @(negedge clk);
    start_i = poke;   // R10: second start while searching
    // R1: inputs scrambled after capture
    chan_i = 4'($urandom); bits_i = 6'($urandom); rate_i = 18'($urandom);
    thresh_i = 16'($urandom); max_lines_i = 3'(1 << ($urandom % 3));
    lat = 0;
    got = 1'b0;
    while (!got && lat < 64) begin
      @(negedge clk);
      start_i = 1'b0;
      lat++;
      if (done_o) got = 1'b1;
    end
    check(got, {tag, " done seen R9"}, int'(got), 1);
    check(int'(code_o) == ecode, {tag, " code R5 R6"}, int'(code_o), ecode);
    check(lat == elat, {tag, " latency R9"}, lat, elat);
    @(negedge clk);
    check(!done_o, {tag, " single pulse R9"}, int'(done_o), 0);
    if (poke) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        check(!done_o, {tag, " stray done R10"}, int'(done_o), 0);
      end
    end
    check(int'(code_o) == ecode, {tag, " code held R12"}, int'(code_o), ecode);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    int rates[8];
    seed = $urandom(32'd20240611);
    rates = '{8000, 44100, 48000, 48001, 88200, 96000, 176400, 192000};
    repeat (3) @(negedge clk);
    check(done_o == 1'b0, "reset done R11", int'(done_o), 0);
    check(code_o == 2'd0, "reset code R11", int'(code_o), 0);
    rst_n = 1'b1;

    run_case(2, 16, 48000, 10, 0, "zero max R8", 1'b0);
    run_case(2, 16, 48000, 16, 4, "equal threshold R5", 1'b0);
    run_case(2, 16, 96000, 16, 4, "rate 96000 R3", 1'b0);
    run_case(2, 16, 95999, 16, 4, "rate 95999 R3", 1'b0);
    run_case(2, 16, 48001, 16, 4, "rate 48001 R3", 1'b0);
    run_case(1, 8, 192000, 8, 4, "rate 192000 R3", 1'b0);
    run_case(7, 1, 48000, 3, 2, "truncation pass R4", 1'b0);
    run_case(7, 1, 48000, 4, 2, "truncation miss R4", 1'b0);
    run_case(2, 16, 48000, 60000, 4, "all miss R7", 1'b0);
    run_case(2, 16, 48000, 60000, 4, "busy start R10", 1'b1);
    run_case(8, 32, 48000, 1, 1, "single line R6", 1'b0);
    run_case(4, 16, 48000, 16, 4, "four lines R2", 1'b0);

    for (int n = 0; n < 300; n++) begin
      int ch;
      int bw;
      int rt;
      int th;
      int ml;
      ch = 1 + int'($urandom % 15);
      bw = 1 + int'($urandom % 63);
      rt = (($urandom % 4) == 0) ? int'($urandom % 262144) : rates[$urandom % 8];
      th = int'($urandom % 600);
      ml = ((($urandom % 4) == 0) ? 0 : (1 << ($urandom % 3)));
      run_case(ch, bw, rt, th, ml, "random R1", ($urandom % 5) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule